// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Store

This block is a read-only, one-bit-wide sequential store. It hands a fixed configuration bitstream to a master device one bit per rising edge of the master's serial clock. The stored image is a parameter, and bit 0 of the image is sent first. A single pin serves as both the counter reset and the output enable. A parameter selects whether that pin is active-high or active-low. An active-low chip-enable input either gates the store or puts it in standby.

Once the last bit has been consumed, the store stops advancing, withdraws its data output and pulls its cascade output low. That cascade output drives the chip-enable of the next store. A row of stores therefore behaves as one long stream on a shared data line. If the reset pin is never pulsed between reads, the read position is kept, so the next read continues with the image that follows. The three-state data pin is modelled as a data bit and a drive-enable bit.

Top module: `cfg_bit_store`

## Requirements
- R1: While `dout_en` is high, `dout` equals bit `a` of `IMAGE`, where `a` is the current read position. After any reset the position is 0, so bit 0 of `IMAGE` (the LSB) is the first bit sent.
- R2: On a rising edge where chip-enable is active (`ce_n` low), output-enable is active and the store is not past its end, the read position advances by exactly one.
- R3: With `RST_POL` = RST_POL_HIGH (the default), a high level on `rst_oe` is reset and a low level is output-enable. With RST_POL_LOW, a low level is reset and a high level is output-enable.
- R4: Every rising edge while the reset level is on `rst_oe` sets the read position to 0 and clears the past-end state, whatever the level of `ce_n`. During that time `dout_en` is low.
- R5: `dout_en` is low whenever `ce_n` is high or output-enable is inactive. While `ce_n` is high, the read position and the past-end state do not change.
- R6: The enabled edge that reads position `DEPTH-1` puts the store past its end. From that edge on, `dout_en` is low, `cascade_n` is low and the position stops advancing.
- R7: Past the end, `cascade_n` equals `ce_n` while output-enable is active. `cascade_n` is high whenever the store is not past its end or output-enable is inactive.
- R8: If no reset level is applied, the read position is kept through any period of standby (`ce_n` high), and reading resumes at the next bit.
- R9: `rst_n` low clears the position at once and forces `dout_en` low and `cascade_n` high. After `rst_n` rises, the store stays in this state until the second rising edge.
- R10: In a chain, the first store's `cascade_n` drives the second store's `ce_n`. At most one store asserts `dout_en` at a time. The second store drives its bit 0 in the cycle right after the edge that consumed the first store's last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock from the master; the position advances on its rising edge |
| rst_n | input | 1 | Power-on reset, asynchronous assert, released after two edges |
| ce_n | input | 1 | Chip-enable, active low; high freezes the store in standby |
| rst_oe | input | 1 | Combined reset / output-enable pin, polarity set by `RST_POL` |
| dout | output | 1 | Serial data bit, valid while `dout_en` is high (0 otherwise) |
| dout_en | output | 1 | Drive enable of the modelled three-state data pin |
| cascade_n | output | 1 | Active-low enable for the next store in the chain |

## Verification
The data, drive-enable and cascade outputs depend combinationally on the pins and on registered state. Their values are therefore due in the same cycle as a pin change, while a read-position change is due one rising edge after the enabling edge. The power-on reset release is due two edges after `rst_n` rises. The bench drives all pins just after the falling edge and samples one nanosecond later, well before the next rising edge. Its reference model updates its own position, past-end flag and reset-synchronizer copy only after each rising edge. As a result, every expected value is compared in the cycle the requirements place it in. Directed sequences pin down the hand-off cycle, the resume after standby and the polarity option. Long random runs of chip-enable and reset pulses then exercise the whole chain against the model.

// File: rtl/cfgstore_pkg.sv
package cfgstore_pkg;

  // Polarity of the combined reset / output-enable pin.
  typedef enum logic {
    RST_POL_LOW  = 1'b0,
    RST_POL_HIGH = 1'b1
  } rst_pol_e;

  // Decoded enable conditions shared by the sequencer and the top.
  typedef struct packed {
    logic live;   // power-on reset released
    logic ce;     // chip-enable active
    logic oe;     // output-enable active (reset level absent)
  } store_gate_t;

endpackage

// File: rtl/cfgstore_gate.sv
module cfgstore_gate
  import cfgstore_pkg::*;
#(
  parameter rst_pol_e RST_POL = RST_POL_HIGH
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        rst_oe,
  output logic        rst_sync_n,
  output store_gate_t gate
);

  logic sync_s1_q;
  logic sync_s2_q;
  logic pin_reset;

  // Reset synchronizer: asynchronous assertion, release after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_s1_q <= 1'b0;
      sync_s2_q <= 1'b0;
    end else begin
      sync_s1_q <= 1'b1;
      sync_s2_q <= sync_s1_q;
    end
  end

  assign rst_sync_n = sync_s2_q;

  generate
    if (RST_POL == RST_POL_HIGH) begin : g_pol_high
      assign pin_reset = rst_oe;
    end else begin : g_pol_low
      assign pin_reset = ~rst_oe;
    end
  endgenerate

  always_comb begin
    gate.live = sync_s2_q;
    gate.ce   = ~ce_n;
    gate.oe   = ~pin_reset;
  end

endmodule

// File: rtl/cfgstore_seq.sv
module cfgstore_seq
  import cfgstore_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          rst_sync_n,
  input  store_gate_t   gate,
  output logic [AW-1:0] addr,
  output logic          past_end
);

  localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          end_q;
  logic          end_d;
  logic          upd_en;

  // Next-state: clear on reset level, step while enabled, stop past end.
  always_comb begin
    addr_d = addr_q;
    end_d  = end_q;
    upd_en = 1'b0;
    if (!gate.oe) begin
      addr_d = '0;
      end_d  = 1'b0;
      upd_en = 1'b1;
    end else if (gate.ce && !end_q) begin
      upd_en = 1'b1;
      if (addr_q == TC) begin
        end_d = 1'b1;
      end else begin
        addr_d = AW'(addr_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      end_q  <= 1'b0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      end_q  <= end_d;
    end
  end

  assign addr     = addr_q;
  assign past_end = end_q;

endmodule

// File: rtl/cfgstore_array.sv
module cfgstore_array #(
  parameter int               DEPTH = 64,
  parameter int               AW    = 6,
  parameter logic [DEPTH-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr,
  output logic          bit_o
);

  localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

  generate
    if (DEPTH == (1 << AW)) begin : g_full
      assign bit_o = IMAGE[addr];
    end else begin : g_guarded
      assign bit_o = (addr <= TC) ? IMAGE[addr] : 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store
  import cfgstore_pkg::*;
#(
  parameter int               DEPTH   = 64,
  parameter logic [DEPTH-1:0] IMAGE   = DEPTH'(64'hC3A5_0F1E_9B62_D478),
  parameter rst_pol_e         RST_POL = RST_POL_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic rst_oe,
  output logic dout,
  output logic dout_en,
  output logic cascade_n
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  store_gate_t   gate;
  logic          rst_sync_n;
  logic [AW-1:0] addr_q;
  logic          past_end;
  logic          cell_bit;
  logic          selected;

  cfgstore_gate #(.RST_POL(RST_POL)) gate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .rst_oe     (rst_oe),
    .rst_sync_n (rst_sync_n),
    .gate       (gate)
  );

  cfgstore_seq #(.DEPTH(DEPTH), .AW(AW)) seq_i (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .gate       (gate),
    .addr       (addr_q),
    .past_end   (past_end)
  );

  cfgstore_array #(.DEPTH(DEPTH), .AW(AW), .IMAGE(IMAGE)) array_i (
    .addr  (addr_q),
    .bit_o (cell_bit)
  );

  assign selected  = gate.live & gate.ce & gate.oe;
  assign dout_en   = selected & ~past_end;
  assign cascade_n = ~(selected & past_end);
  assign dout      = dout_en & cell_bit;

endmodule

// File: rtl/cfg_bit_store_chk.sv
module cfg_bit_store_chk
  import cfgstore_pkg::*;
#(
  parameter int       DEPTH   = 64,
  parameter int       AW      = 6,
  parameter rst_pol_e RST_POL = RST_POL_HIGH
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          ce_n,
  input logic          rst_oe,
  input logic          dout_en,
  input logic          cascade_n,
  input logic [AW-1:0] addr,
  input logic          past_end
);

  localparam logic [AW-1:0] TC = AW'(DEPTH - 1);

  logic rst_lvl;
  assign rst_lvl = (RST_POL == RST_POL_HIGH) ? rst_oe : ~rst_oe;

  // R4: reset level returns the position to zero on the next edge
  a_r4_pin_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_lvl |=> (addr == '0 && !past_end));

  // R2: enabled edge before the end steps the position by one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ce_n && !rst_lvl && !past_end && addr != TC) |=> (addr == AW'($past(addr) + 1'b1)));

  // R5: standby freezes the position and the end state
  a_r5_standby_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ce_n && !rst_lvl) |=> ($stable(addr) && $stable(past_end)));

  // R6: reading the last position moves the store past its end
  a_r6_end_reached: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ce_n && !rst_lvl && !past_end && addr == TC) |=> (past_end && !dout_en));

  // R6: past the end the position stays put until a reset level
  a_r6_end_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (past_end && !rst_lvl) |=> (past_end && $stable(addr)));

  // R7: past the end the cascade output follows chip-enable
  a_r7_cascade_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (past_end && !rst_lvl) |-> (cascade_n == ce_n));

  // R10: a store never drives data while enabling its successor
  a_r10_one_driver: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(dout_en && !cascade_n));

  // R9: power-on reset keeps outputs quiet and the position at zero
  a_r9_por_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (!dout_en && cascade_n && addr == '0));

endmodule

bind cfg_bit_store cfg_bit_store_chk #(
  .DEPTH   (DEPTH),
  .AW      (AW),
  .RST_POL (RST_POL)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .ce_n       (ce_n),
  .rst_oe     (rst_oe),
  .dout_en    (dout_en),
  .cascade_n  (cascade_n),
  .addr       (addr_q),
  .past_end   (past_end)
);

// File: tb/cfg_bit_store_tb_top.sv
module cfg_bit_store_tb_top;
  import cfgstore_pkg::*;

  localparam logic [15:0] IMG_A = 16'hB38D;
  localparam logic [11:0] IMG_B = 12'h5C6;
  localparam logic [7:0]  IMG_C = 8'h96;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, pin_ab, ce_head_n, pin_c, ce_c_n;
  logic a_d, a_en, a_cas, b_d, b_en, b_cas, c_d, c_en, c_cas;

  // Chain A -> B with active-low reset pin; C alone with the default polarity.
  cfg_bit_store #(.DEPTH(16), .IMAGE(IMG_A), .RST_POL(RST_POL_LOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_head_n), .rst_oe(pin_ab),
    .dout(a_d), .dout_en(a_en), .cascade_n(a_cas));
  cfg_bit_store #(.DEPTH(12), .IMAGE(IMG_B), .RST_POL(RST_POL_LOW)) cas_i (
    .clk(clk), .rst_n(rst_n), .ce_n(a_cas), .rst_oe(pin_ab),
    .dout(b_d), .dout_en(b_en), .cascade_n(b_cas));
  cfg_bit_store #(.DEPTH(8), .IMAGE(IMG_C)) pol_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_c_n), .rst_oe(pin_c),
    .dout(c_d), .dout_en(c_en), .cascade_n(c_cas));

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  int   m_addr [3];
  bit   m_end  [3];
  bit   m_s1, m_s2;
  bit   x_en [3];
  bit   x_oe [3];
  int   nbits [3] = '{16, 12, 8};
  logic [15:0] img [3] = '{IMG_A, {4'h0, IMG_B}, {8'h00, IMG_C}};

  task automatic expect_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic bus_val();
    return a_en ? a_d : (b_en ? b_d : 1'bz);
  endfunction

  // Compute expectations from the pins and compare all outputs.
  task automatic check_all();
    bit ce [3];
    bit x_cas [3];
    logic act_en [3], act_d [3], act_cas [3];
    if (!rst_n) begin m_s1 = 0; m_s2 = 0; end
    act_en  = '{a_en, b_en, c_en};
    act_d   = '{a_d, b_d, c_d};
    act_cas = '{a_cas, b_cas, c_cas};
    x_oe[0] = pin_ab; x_oe[1] = pin_ab; x_oe[2] = ~pin_c;   // R3 polarity
    ce[0] = ~ce_head_n; ce[2] = ~ce_c_n;
    for (int k = 0; k < 3; k++) begin
      if (k == 1) ce[1] = ~x_cas[0];
      x_en[k]  = m_s2 && ce[k] && x_oe[k] && !m_end[k];
      x_cas[k] = !(m_s2 && ce[k] && x_oe[k] && m_end[k]);
      expect_bit($sformatf("R5 dout_en store%0d", k), act_en[k], x_en[k]);
      expect_bit($sformatf("R7 cascade_n store%0d", k), act_cas[k], x_cas[k]);
      if (x_en[k])
        expect_bit($sformatf("R1 dout store%0d pos%0d", k, m_addr[k]), act_d[k], img[k][m_addr[k]]);
    end
    expect_bit("R10 single driver", a_en & b_en, 1'b0);
  endtask

  task automatic model_edge();
    for (int k = 0; k < 3; k++) begin
      if (!m_s2 || !x_oe[k]) begin
        m_addr[k] = 0; m_end[k] = 0;
      end else if (x_en[k]) begin
        if (m_addr[k] == nbits[k] - 1) m_end[k] = 1;
        else m_addr[k]++;
      end
    end
    m_s2 = m_s1;
    m_s1 = rst_n;
  endtask

  task automatic settle(); #1; check_all(); endtask
  task automatic step(); @(posedge clk); model_edge(); @(negedge clk); endtask
  task automatic cyc(); settle(); step(); endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(20240611);
    for (int k = 0; k < 3; k++) begin m_addr[k] = 0; m_end[k] = 0; end
    m_s1 = 0; m_s2 = 0;
    rst_n = 0; pin_ab = 1; ce_head_n = 0; pin_c = 1; ce_c_n = 1;
    @(negedge clk);

    // R9: power-on reset keeps everything quiet even with enables active
    settle();
    expect_bit("R9 dout_en in power-on reset", a_en, 1'b0);
    expect_bit("R9 cascade_n in power-on reset", a_cas, 1'b1);
    step();
    rst_n = 1; ce_head_n = 0;
    settle();
    expect_bit("R9 quiet first cycle after release", a_en, 1'b0);
    step();
    settle();
    expect_bit("R9 quiet second cycle after release", a_en, 1'b0);
    step();

    // Full chained read-out: 16 bits of A then 12 of B (R1, R2, R6, R10)
    for (int k = 0; k < 32; k++) begin
      settle();
      if (k < 16) begin
        expect_bit($sformatf("R2 A drives stream bit %0d", k), bus_val(), IMG_A[k]);
      end else if (k < 28) begin
        expect_bit($sformatf("R10 B drives stream bit %0d", k), bus_val(), IMG_B[k-16]);
        if (k == 16) begin
          expect_bit("R6 A released one edge after last bit", a_en, 1'b0);
          expect_bit("R6 A cascade low at hand-off", a_cas, 1'b0);
          expect_bit("R10 B enabled at hand-off", b_en, 1'b1);
        end
      end else begin
        expect_bit("R6 nobody drives after both ends", a_en | b_en, 1'b0);
        expect_bit("R7 B cascade low after its end", b_cas, 1'b0);
      end
      step();
    end

    // R4: reset level on the pin rewinds both stores
    pin_ab = 0;
    settle();
    expect_bit("R4 no driver while reset level", a_en | b_en, 1'b0);
    expect_bit("R7 A cascade high while reset level", a_cas, 1'b1);
    step();
    pin_ab = 1;
    for (int k = 0; k < 17; k++) begin
      settle();
      if (k == 0)  expect_bit("R4 A restarts at bit 0", bus_val(), IMG_A[0]);
      if (k == 16) expect_bit("R4 B restarts at bit 0", bus_val(), IMG_B[0]);
      step();
    end

    // R8 and R5: read part of A, standby, resume where it stopped
    pin_ab = 0; cyc(); pin_ab = 1;
    for (int k = 0; k < 5; k++) cyc();
    ce_head_n = 1;
    for (int k = 0; k < 4; k++) begin
      settle();
      expect_bit("R5 no driver in standby", a_en | b_en, 1'b0);
      step();
    end
    ce_head_n = 0;
    settle();
    expect_bit("R8 resume at bit 5", bus_val(), IMG_A[5]);
    step();
    for (int k = 0; k < 10; k++) cyc();

    // R7: past the end, A cascade follows chip-enable
    ce_head_n = 1;
    settle();
    expect_bit("R7 cascade high with ce_n high", a_cas, 1'b1);
    step();
    ce_head_n = 0;
    settle();
    expect_bit("R7 cascade low with ce_n low", a_cas, 1'b0);
    step();

    // R3: default polarity store, high level resets
    pin_c = 1; ce_c_n = 0;
    settle();
    expect_bit("R3 high level is reset on default polarity", c_en, 1'b0);
    step();
    pin_c = 0;
    settle();
    expect_bit("R3 low level enables output", c_en, 1'b1);
    expect_bit("R3 first bit after reset", c_d, IMG_C[0]);
    step();

    // Random mix of chip-enable and reset pulses
    for (int k = 0; k < 4000; k++) begin
      pin_ab    = ($urandom_range(99) < 3) ? 1'b0 : 1'b1;
      ce_head_n = ($urandom_range(99) < 20) ? 1'b1 : 1'b0;
      pin_c     = ($urandom_range(99) < 5) ? 1'b1 : 1'b0;
      ce_c_n    = ($urandom_range(99) < 25) ? 1'b1 : 1'b0;
      cyc();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule